// File: doc/BRIEF.md
# Flash Ready-Wait Status Poller

After a serial NAND command (page read, program, erase or reset) has been sent, this block waits for the device to become ready again. A start pulse names the kind of operation. The block first lets an initial delay pass. It then asks a command engine, through a request/done handshake, to fetch the device status byte. It keeps asking at a fixed poll interval for as long as the busy flag in that byte stays set. Each operation kind has its own initial delay and its own poll interval. Time is counted in microsecond ticks that arrive on a separate input.

A watchdog measures the whole wait, starting at the start pulse and including the initial delay. When it runs out, the wait is abandoned and reported as a timeout. A status fetch that is still in flight at that moment is allowed to complete, but its byte is thrown away.

When the device reports ready, the block presents the final status byte. It also decodes a failure flag that matches the operation kind, and a two-bit error-correction outcome for page reads only.

Top module: `nand_ready_poller`

## Requirements
- R1: Every status fetch is a request with `rd_opcode` = 0x0F and `rd_addr` = 0xC0. `rd_req` stays high until the cycle in which `rd_done` is sampled high, and it is never high while the block is idle.
- R2: `op_kind` is encoded as 0 = page read, 1 = program, 2 = erase and 3 = reset. The first fetch is requested after the initial delay of that kind has elapsed, counted in ticks from the start pulse. The defaults are 6, 75, 250 and 5 µs.
- R3: A returned byte with bit 0 set means the device is busy. The next fetch is then requested once the poll interval of the operation kind has elapsed. The defaults are 5, 15, 50 and 5 µs.
- R4: A returned byte with bit 0 clear ends the wait. `done` pulses high for one cycle, `final_status` carries the byte, and `busy` falls. The results stay unchanged until the next wait ends.
- R5: `op_fail` equals bit 2 of the final byte for an erase and bit 3 for a program. It is 0 for a page read and for a reset.
- R6: `ecc_code` equals bits 5:4 of the final byte for a page read (00 clean, 01 corrected, 10 uncorrectable). It is 00 for all other kinds.
- R7: When `TIMEOUT_US` ticks have passed since the start pulse, the wait ends with `timed_out` = 1, `final_status` = 0, `op_fail` = 0 and `ecc_code` = 0. A busy reply sampled on the tick at which the timeout expires is discarded.
- R8: A fetch that is still in flight when the timeout expires is completed. `done` follows only the cycle in which its `rd_done` is sampled, and its byte is discarded as described in R7.
- R9: A start pulse that arrives while a wait is in progress is ignored. It changes neither the timing nor the decoding of the current wait.
- R10: Delays and the timeout advance only on cycles with `us_tick` high. While no ticks arrive, no new fetch is requested.
- R11: After reset, `busy`, `done`, `rd_req` and `timed_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| start | input | 1 | Begin a wait (accepted only when idle) |
| op_kind | input | 2 | Operation kind: 0 read, 1 program, 2 erase, 3 reset |
| rd_req | output | 1 | Status fetch request to the command engine |
| rd_opcode | output | 8 | Opcode of the fetch (0x0F) |
| rd_addr | output | 8 | Register address of the fetch (0xC0) |
| rd_done | input | 1 | Fetch finished; `rd_data` valid |
| rd_data | input | 8 | Status byte returned by the fetch |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle pulse when a wait ends |
| final_status | output | 8 | Last ready status byte (0 on timeout) |
| op_fail | output | 1 | Failure bit matching the operation kind |
| ecc_code | output | 2 | Error-correction outcome for page reads |
| timed_out | output | 1 | The last wait ended by timeout |

## Verification
The bench shrinks the delays to a few ticks: read 3/2, program 6/3, erase 9/4 and reset 2/2, with a 40-tick timeout. With these values, a sweep over every operation kind and over 0 to 12 busy replies crosses the point at which the timeout overtakes completion. At the edge where completion and timeout coincide, the bench predicts the cycle in which `done` appears arithmetically. The final bytes vary their fail and error-correction bits across the sweep, so all four decode rules are exercised. Separate runs cover a slow command engine that straddles the timeout, a second start pulse during a wait, and a stretch with no ticks.

// File: rtl/nand_ready_poller.sv
module nand_ready_poller #(
  parameter int READ_INIT_US  = 6,
  parameter int READ_POLL_US  = 5,
  parameter int PROG_INIT_US  = 75,
  parameter int PROG_POLL_US  = 15,
  parameter int ERASE_INIT_US = 250,
  parameter int ERASE_POLL_US = 50,
  parameter int RST_INIT_US   = 5,
  parameter int RST_POLL_US   = 5,
  parameter int TIMEOUT_US    = 400000,
  parameter logic [7:0] STATUS_OPCODE = 8'h0F,
  parameter logic [7:0] STATUS_REG    = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic [1:0] op_kind,
  output logic       rd_req,
  output logic [7:0] rd_opcode,
  output logic [7:0] rd_addr,
  input  logic       rd_done,
  input  logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic [7:0] final_status,
  output logic       op_fail,
  output logic [1:0] ecc_code,
  output logic       timed_out
);
  localparam int M1 = (READ_INIT_US > READ_POLL_US) ? READ_INIT_US : READ_POLL_US;
  localparam int M2 = (PROG_INIT_US > PROG_POLL_US) ? PROG_INIT_US : PROG_POLL_US;
  localparam int M3 = (ERASE_INIT_US > ERASE_POLL_US) ? ERASE_INIT_US : ERASE_POLL_US;
  localparam int M4 = (RST_INIT_US > RST_POLL_US) ? RST_INIT_US : RST_POLL_US;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int M34 = (M3 > M4) ? M3 : M4;
  localparam int DMAX = (M12 > M34) ? M12 : M34;
  localparam int DW = $clog2(DMAX + 1);
  localparam int TW = $clog2(TIMEOUT_US + 1);

  localparam logic [1:0] K_READ  = 2'd0;
  localparam logic [1:0] K_PROG  = 2'd1;
  localparam logic [1:0] K_ERASE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ} state_t;

  state_t         state;
  logic [1:0]     op_q;
  logic [DW-1:0]  dly;
  logic [TW-1:0]  elapsed;
  logic           late;
  logic [DW-1:0]  init_sel, poll_sel;
  logic           expire;

  assign rd_opcode = STATUS_OPCODE;
  assign rd_addr   = STATUS_REG;
  assign rd_req    = (state == S_REQ);
  assign busy      = (state != S_IDLE);
  assign expire    = us_tick && (elapsed == TW'(TIMEOUT_US - 1));

  always_comb begin
    case (op_kind)
      2'd0:    init_sel = DW'(READ_INIT_US);
      2'd1:    init_sel = DW'(PROG_INIT_US);
      2'd2:    init_sel = DW'(ERASE_INIT_US);
      default: init_sel = DW'(RST_INIT_US);
    endcase
    case (op_q)
      2'd0:    poll_sel = DW'(READ_POLL_US);
      2'd1:    poll_sel = DW'(PROG_POLL_US);
      2'd2:    poll_sel = DW'(ERASE_POLL_US);
      default: poll_sel = DW'(RST_POLL_US);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      op_q         <= 2'd0;
      dly          <= '0;
      elapsed      <= '0;
      late         <= 1'b0;
      done         <= 1'b0;
      final_status <= 8'h00;
      op_fail      <= 1'b0;
      ecc_code     <= 2'b00;
      timed_out    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q    <= op_kind;
          dly     <= init_sel;
          elapsed <= '0;
          late    <= 1'b0;
          state   <= S_WAIT;
        end
        S_WAIT: if (us_tick) begin
          elapsed <= elapsed + 1'b1;
          if (expire) begin
            state        <= S_IDLE;
            done         <= 1'b1;
            timed_out    <= 1'b1;
            final_status <= 8'h00;
            op_fail      <= 1'b0;
            ecc_code     <= 2'b00;
          end else if (dly <= DW'(1)) begin
            state <= S_REQ;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        default: begin
          if (us_tick && !late) begin
            elapsed <= elapsed + 1'b1;
            if (expire) late <= 1'b1;
          end
          if (rd_done) begin
            if (late || (expire && !late)) begin
              state        <= S_IDLE;
              done         <= 1'b1;
              timed_out    <= 1'b1;
              final_status <= 8'h00;
              op_fail      <= 1'b0;
              ecc_code     <= 2'b00;
            end else if (rd_data[0]) begin
              dly   <= poll_sel;
              state <= S_WAIT;
            end else begin
              state        <= S_IDLE;
              done         <= 1'b1;
              timed_out    <= 1'b0;
              final_status <= rd_data;
              op_fail      <= ((op_q == K_ERASE) && rd_data[2]) ||
                              ((op_q == K_PROG) && rd_data[3]);
              ecc_code     <= (op_q == K_READ) ? rd_data[5:4] : 2'b00;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_ready_poller_chk.sv
module nand_ready_poller_chk #(
  parameter int TW = 8,
  parameter int TIMEOUT_US = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          rd_req,
  input logic          rd_done,
  input logic          timed_out,
  input logic          op_fail,
  input logic [1:0]    ecc_code,
  input logic [1:0]    op_q,
  input logic [TW-1:0] elapsed
);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_done |=> rd_req);
  a_r1_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_req);
  a_r5_fail_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_fail |-> (op_q == 2'd1 || op_q == 2'd2));
  a_r6_ecc_read: assert property (@(posedge clk) disable iff (!rst_n)
    done && ecc_code != 2'b00 |-> op_q == 2'd0);
  a_r7_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done && timed_out |-> !op_fail && ecc_code == 2'b00);
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed <= TW'(TIMEOUT_US));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(op_q));
endmodule

bind nand_ready_poller nand_ready_poller_chk #(.TW(TW), .TIMEOUT_US(TIMEOUT_US)) chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .rd_req(rd_req), .rd_done(rd_done), .timed_out(timed_out),
  .op_fail(op_fail), .ecc_code(ecc_code), .op_q(op_q), .elapsed(elapsed)
);

// File: tb/nand_ready_poller_test.sv
module nand_ready_poller_test;
  localparam int T = 40;

  logic clk = 0, rst_n = 0, us_tick = 1, start = 0, rd_done = 0;
  logic [1:0] op_kind = 0;
  logic [7:0] rd_data = 0;
  logic rd_req, busy, done, op_fail, timed_out;
  logic [7:0] rd_opcode, rd_addr, final_status;
  logic [1:0] ecc_code;

  int checks = 0, fails = 0;
  int busy_left, resp_lat, wait_cnt, polls, bad_cmd;
  logic [7:0] resp_final;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_ready_poller #(
    .READ_INIT_US(3), .READ_POLL_US(2), .PROG_INIT_US(6), .PROG_POLL_US(3),
    .ERASE_INIT_US(9), .ERASE_POLL_US(4), .RST_INIT_US(2), .RST_POLL_US(2),
    .TIMEOUT_US(T)
  ) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start), .op_kind(op_kind),
    .rd_req(rd_req), .rd_opcode(rd_opcode), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .busy(busy), .done(done), .final_status(final_status),
    .op_fail(op_fail), .ecc_code(ecc_code), .timed_out(timed_out)
  );

  function automatic int init_of(int k);
    return (k == 0) ? 3 : (k == 1) ? 6 : (k == 2) ? 9 : 2;
  endfunction
  function automatic int poll_of(int k);
    return (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 4 : 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_done = 0;
    end else if (rd_done) begin
      rd_done = 0;
    end else if (rd_req) begin
      if (wait_cnt < resp_lat) wait_cnt++;
      else begin
        wait_cnt = 0;
        rd_done = 1;
        polls++;
        if (rd_opcode != 8'h0F || rd_addr != 8'hC0) bad_cmd++;
        if (busy_left > 0) begin
          rd_data = 8'hFF;
          busy_left--;
        end else rd_data = resp_final;
      end
    end
  end

  task automatic run(input int k, input int nbusy, input logic [7:0] fin,
                     input int lat, input bit disturb, output int n);
    busy_left = nbusy; resp_final = fin; resp_lat = lat;
    wait_cnt = 0; polls = 0; bad_cmd = 0;
    @(negedge clk); op_kind = 2'(k); start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    n = 0;
    while (n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (disturb && n == 2) begin op_kind = 2'd1; start = 1; end
      else start = 0;
      if (done) break;
    end
    start = 0;
  endtask

  initial begin
    int n, d, expn, exppolls;
    logic [7:0] fin;
    repeat (3) @(negedge clk);
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 rd_req", rd_req, 0);
    check("R11 timed_out", timed_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 4; k++) begin
      for (int nb = 0; nb <= 12; nb++) begin
        fin = {nb[1:0], 4'((nb + k) % 16), 1'b1, 1'b0} & 8'hFE;
        run(k, nb, fin, 0, 0, n);
        d = init_of(k) + nb * (poll_of(k) + 1) + 1;
        expn = (d < T) ? d : T;
        check("R2 R3 done edge", n, expn);
        check("R1 command", bad_cmd, 0);
        check("R4 busy low", busy, 0);
        if (d < T) begin
          check("R3 polls", polls, nb + 1);
          check("R4 status", final_status, fin);
          check("R7 no timeout", timed_out, 0);
          check("R5 fail", op_fail, (k == 2) ? fin[2] : (k == 1) ? fin[3] : 0);
          check("R6 ecc", ecc_code, (k == 0) ? fin[5:4] : 0);
        end else begin
          exppolls = 0;
          for (int j = 0; init_of(k) + j * (poll_of(k) + 1) < T; j++) exppolls++;
          check("R7 polls", polls, exppolls);
          check("R7 timeout", timed_out, 1);
          check("R7 status", final_status, 0);
          check("R7 fail", op_fail, 0);
          check("R7 ecc", ecc_code, 0);
        end
        repeat (2) @(negedge clk);
      end
    end

    run(0, 100, 8'h00, 8, 0, n);
    check("R8 timeout", timed_out, 1);
    check("R8 status discarded", final_status, 0);
    check("R8 held past expiry", (n > T && n <= T + 9) ? 1 : 0, 1);
    repeat (2) @(negedge clk);

    run(2, 2, 8'h0C, 0, 1, n);
    check("R9 timing", n, 9 + 2 * 5 + 1);
    check("R9 erase decode", op_fail, 1);
    check("R9 status", final_status, 8'h0C);
    repeat (2) @(negedge clk);

    busy_left = 0; resp_final = 8'h10; resp_lat = 0; polls = 0; wait_cnt = 0;
    @(negedge clk); us_tick = 0; op_kind = 2'd0; start = 1;
    @(negedge clk); start = 0;
    repeat (50) @(negedge clk);
    check("R10 no request", polls, 0);
    check("R10 still busy", busy, 1);
    us_tick = 1;
    n = 0;
    while (n < 100 && !done) begin @(negedge clk); n++; end
    check("R10 resumes", n, 4);
    check("R6 ecc corrected", ecc_code, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule